// File: doc/BRIEF.md
# Multi-Sequencer ADC Sample Front End

This block is the digital side of an analog-to-digital converter that serves four independent sample sequencers. Each sequencer owns a 16-entry result FIFO, a packed status word that shows both FIFO pointers and the empty and full flags, a channel-mux register, a control register and one interrupt bit. A processor reaches all of it through a simple register port. Reads of a sequencer's data register return the combinational value in the same cycle and remove the entry at the next clock edge.

A single timer trigger input fans out. On a trigger pulse, every sequencer that is both enabled and set to the timer event code gets one new sample and raises its raw interrupt bit. No converter is present. A 32-bit linear congruential generator stands in for it and produces samples that sit just above mid-scale with a little noise. When a sample arrives at a full FIFO it is dropped, and the block records the loss in an overflow register.

Top module: `adc_seq_sampler`

## Requirements
- R1: After reset every sequencer status word reads 0x100: EMPTY set, FULL clear, and both pointers zero. The enable, raw interrupt, mask and overflow registers read 0, and the interrupt outputs are low.
- R2: A trigger pulse delivers one sample to sequencer n only when enable bit n (register 0x00, bits 3:0) is set and nibble n of the event register (0x14, bits 4n+3:4n) equals 5. A sequencer that fails either condition keeps its status word.
- R3: The noise state starts at 0. It advances as noise = noise*314159 + 1 (mod 2^32) once for each delivered sample, sequencers taken from 0 upward, and it also advances when the sample is dropped. The stored value is 0x200 plus bits 18:16 of the advanced noise.
- R4: The status word of sequencer n sits at 0x4C+0x20n and has the read pointer in bits 3:0, the write pointer in bits 7:4, EMPTY in bit 8 and FULL in bit 12. A read of the data register at 0x48+0x20n returns the entry at the read pointer. The same read advances the read pointer modulo 16, clears FULL, and sets EMPTY when the pointers meet. A push advances the write pointer, clears EMPTY, and sets FULL when the pointers meet.
- R5: Reading the data register of an empty FIFO leaves its status word unchanged.
- R6: A sample arriving at a full FIFO is discarded and leaves the pointers and flags alone. It sets bit n of the overflow register at 0x10.
- R7: Each delivered or dropped sample sets raw interrupt bit n (register 0x04). Writing 1s to 0x0C clears the matching raw bits. A new set in the same cycle takes priority over the clear.
- R8: Interrupt output n equals raw bit n AND mask bit n (mask register 0x08, bits 3:0). Register 0x0C reads the masked value.
- R9: Writing 1s to the overflow register clears the matching bits.
- R10: The mux register at 0x40+0x20n keeps only the bits in 0x33333333. The enable and mask registers keep bits 3:0, and the event register keeps bits 15:0. The control register at 0x44+0x20n keeps all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; pops the FIFO when it addresses a data register |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| trigIn | input | 1 | Timer trigger pulse, one cycle per event |
| irqOut | output | 4 | Per-sequencer interrupt lines |

## Verification
The bench fills a FIFO from a nonzero read pointer until it is full, then fires one more trigger. A design that let the dropped sample overwrite data, moved a pointer or failed to advance the noise state shows this as a wrong status word, a wrong overflow bit or a mismatched value in the drain that follows. The drain runs through the wrap of the pointer from 15 to 0 and checks that the first pop clears FULL. A read of an empty FIFO catches a design that moves the pointer anyway. A fan-out pattern with one sequencer enabled but not set to the timer code, and another set to the timer code but not enabled, catches decoding that tests only one of the two conditions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int unsigned SEQ_N   = 4;
  parameter int unsigned SMP_W   = 10;
  parameter int unsigned PTR_W   = 4;
  parameter int unsigned STAT_W  = 13;
  localparam int unsigned IDX_W  = $clog2(SEQ_N);

  // strobes from control to the FIFO datapath
  typedef struct packed {
    logic [SEQ_N-1:0]            push;
    logic [SEQ_N-1:0]            pop;
    logic [SEQ_N-1:0][SMP_W-1:0] sample;
  } seqCmd_t;
endpackage

// File: rtl/adc_seq_slot.sv
module adc_seq_slot
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [SMP_W-1:0]  sample,
  output logic [SMP_W-1:0]  dout,
  output logic [STAT_W-1:0] status,
  output logic              dropped
);
  localparam int unsigned DEPTH = 1 << PTR_W;

  logic [SMP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr, rdAfter, wrAfter;
  logic             emptyF, fullF, emptyMid, fullMid, emptyNext, fullNext, doWrite;

  // pop is applied first, then a push sees the post-pop state
  always_comb begin
    rdAfter  = rdPtr;
    emptyMid = emptyF;
    fullMid  = fullF;
    if (pop && !emptyF) begin
      rdAfter  = rdPtr + 1'b1;
      fullMid  = 1'b0;
      emptyMid = (rdAfter == wrPtr);
    end
    wrAfter   = wrPtr;
    emptyNext = emptyMid;
    fullNext  = fullMid;
    doWrite   = 1'b0;
    if (push && !fullMid) begin
      doWrite   = 1'b1;
      wrAfter   = wrPtr + 1'b1;
      emptyNext = 1'b0;
      fullNext  = (wrAfter == rdAfter);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      emptyF <= 1'b1;
      fullF  <= 1'b0;
    end else begin
      rdPtr  <= rdAfter;
      wrPtr  <= wrAfter;
      emptyF <= emptyNext;
      fullF  <= fullNext;
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= sample;
  end

  assign dout    = mem[rdPtr];
  assign dropped = push && fullMid;
  assign status  = {fullF, 3'b000, emptyF, wrPtr, rdPtr};
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  seqCmd_t                          cmd,
  output logic [SEQ_N-1:0][SMP_W-1:0]      fifoDout,
  output logic [SEQ_N-1:0][STAT_W-1:0]     fifoStat,
  output logic [SEQ_N-1:0]                 dropped
);
  for (genvar g = 0; g < SEQ_N; g++) begin : gSlot
    adc_seq_slot u_slot (
      .clk     (clk),
      .rstN    (rstN),
      .push    (cmd.push[g]),
      .pop     (cmd.pop[g]),
      .sample  (cmd.sample[g]),
      .dout    (fifoDout[g]),
      .status  (fifoStat[g]),
      .dropped (dropped[g])
    );
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter logic [31:0] LCG_MUL  = 32'd314159,
  parameter logic [31:0] LCG_INC  = 32'd1,
  parameter logic [3:0]  EV_TIMER = 4'd5,
  parameter logic [31:0] MUX_KEEP = 32'h3333_3333
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [7:0]                   addr,
  input  logic [31:0]                  wdata,
  input  logic                         trigIn,
  input  logic [SEQ_N-1:0][SMP_W-1:0]  fifoDout,
  input  logic [SEQ_N-1:0][STAT_W-1:0] fifoStat,
  input  logic [SEQ_N-1:0]             dropped,
  output seqCmd_t                      cmd,
  output logic [31:0]                  rdata,
  output logic [SEQ_N-1:0]             irqOut,
  output logic [SEQ_N-1:0]             actSel,
  output logic [4*SEQ_N-1:0]           evMux,
  output logic [SEQ_N-1:0]             intMask,
  output logic [SEQ_N-1:0]             rawSt
);
  localparam logic [7:0] A_ACT = 8'h00, A_RAW = 8'h04, A_MASK = 8'h08,
                         A_CLR = 8'h0C, A_OVF = 8'h10, A_EV   = 8'h14;
  localparam logic [7:0] SEQ_BASE = 8'h40;
  localparam logic [7:0] SEQ_END  = SEQ_BASE + 8'(32 * SEQ_N);

  logic [SEQ_N-1:0]  ovfSt, hit, w1cRaw, w1cOvf;
  logic [31:0]       muxReg [SEQ_N];
  logic [31:0]       ctlReg [SEQ_N];
  logic [31:0]       noise, noiseNext, nz;
  logic [7:0]        relAddr;
  logic [IDX_W-1:0]  seqIdx;
  logic [4:0]        seqOff;
  logic              inSeq;

  assign relAddr = addr - SEQ_BASE;
  assign seqIdx  = relAddr[5 +: IDX_W];
  assign seqOff  = relAddr[4:0];
  assign inSeq   = (addr >= SEQ_BASE) && (addr < SEQ_END);

  // selection and noise chain, lowest sequencer first
  always_comb begin
    nz = noise;
    for (int n = 0; n < SEQ_N; n++) begin
      hit[n] = trigIn && actSel[n] && (evMux[4*n +: 4] == EV_TIMER);
      cmd.sample[n] = '0;
      if (hit[n]) nz = nz * LCG_MUL + LCG_INC;
      cmd.sample[n] = SMP_W'(10'h200) + SMP_W'(nz[18:16]);
      cmd.pop[n] = rdEn && inSeq && (seqIdx == IDX_W'(n)) && (seqOff == 5'h08);
    end
    cmd.push  = hit;
    noiseNext = nz;
  end

  assign w1cRaw = (wrEn && addr == A_CLR) ? wdata[SEQ_N-1:0] : '0;
  assign w1cOvf = (wrEn && addr == A_OVF) ? wdata[SEQ_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSel  <= '0;
      evMux   <= '0;
      intMask <= '0;
      rawSt   <= '0;
      ovfSt   <= '0;
      noise   <= '0;
      for (int n = 0; n < SEQ_N; n++) begin
        muxReg[n] <= '0;
        ctlReg[n] <= '0;
      end
    end else begin
      noise <= noiseNext;
      rawSt <= (rawSt & ~w1cRaw) | hit;
      ovfSt <= (ovfSt & ~w1cOvf) | dropped;
      if (wrEn) begin
        if (inSeq) begin
          if (seqOff == 5'h00) muxReg[seqIdx] <= wdata & MUX_KEEP;
          if (seqOff == 5'h04) ctlReg[seqIdx] <= wdata;
        end else begin
          case (addr)
            A_ACT:   actSel  <= wdata[SEQ_N-1:0];
            A_MASK:  intMask <= wdata[SEQ_N-1:0];
            A_EV:    evMux   <= wdata[4*SEQ_N-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (inSeq) begin
      case (seqOff)
        5'h00:   rdata = muxReg[seqIdx];
        5'h04:   rdata = ctlReg[seqIdx];
        5'h08:   rdata = 32'(fifoDout[seqIdx]);
        5'h0C:   rdata = 32'(fifoStat[seqIdx]);
        default: rdata = '0;
      endcase
    end else begin
      case (addr)
        A_ACT:   rdata = 32'(actSel);
        A_RAW:   rdata = 32'(rawSt);
        A_MASK:  rdata = 32'(intMask);
        A_CLR:   rdata = 32'(rawSt & intMask);
        A_OVF:   rdata = 32'(ovfSt);
        A_EV:    rdata = 32'(evMux);
        default: rdata = '0;
      endcase
    end
  end

  assign irqOut = rawSt & intMask;
endmodule

// File: rtl/adc_seq_sampler.sv
module adc_seq_sampler
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        trigIn,
  output logic [3:0]  irqOut
);
  seqCmd_t                      cmd;
  logic [SEQ_N-1:0][SMP_W-1:0]  fifoDout;
  logic [SEQ_N-1:0][STAT_W-1:0] statW;
  logic [SEQ_N-1:0]             dropped, actSel, intMask, rawSt;
  logic [4*SEQ_N-1:0]           evMux;

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .trigIn(trigIn), .fifoDout(fifoDout), .fifoStat(statW),
    .dropped(dropped), .cmd(cmd), .rdata(rdata), .irqOut(irqOut),
    .actSel(actSel), .evMux(evMux), .intMask(intMask), .rawSt(rawSt)
  );

  adc_seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .fifoDout(fifoDout), .fifoStat(statW), .dropped(dropped)
  );
endmodule

// File: rtl/adc_seq_sampler_chk.sv
module adc_seq_sampler_chk
  import adc_seq_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         trigIn,
  input logic                         rdEn,
  input logic [7:0]                   addr,
  input logic [3:0]                   irqOut,
  input logic [SEQ_N-1:0]             actSel,
  input logic [4*SEQ_N-1:0]           evMux,
  input logic [SEQ_N-1:0]             intMask,
  input logic [SEQ_N-1:0]             rawSt,
  input logic [SEQ_N-1:0][STAT_W-1:0] statW
);
  logic [SEQ_N-1:0] selVec;
  always_comb
    for (int n = 0; n < SEQ_N; n++)
      selVec[n] = actSel[n] && (evMux[4*n +: 4] == 4'd5);

  // R7: a trigger sets raw bits of all selected sequencers
  a_r7_raw_on_trigger: assert property (@(posedge clk) disable iff (!rstN)
    trigIn |=> ((rawSt & $past(selVec)) == $past(selVec)));

  // R8: no interrupt line is high while its mask bit is clear
  a_r8_irq_masked_only: assert property (@(posedge clk) disable iff (!rstN)
    (SEQ_N'(irqOut) & ~intMask) == '0);

  for (genvar g = 0; g < SEQ_N; g++) begin : gSeq
    localparam logic [7:0] POP_ADDR = 8'h48 + 8'(32 * g);

    // R4: empty and full never both set
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
      !(statW[g][8] && statW[g][12]));

    // R5: reading an empty FIFO without a push moves nothing
    a_r5_empty_read_hold: assert property (@(posedge clk) disable iff (!rstN)
      (statW[g][8] && rdEn && addr == POP_ADDR && !trigIn) |=> $stable(statW[g]));

    // R6: a full FIFO stays full until it is read
    a_r6_full_hold: assert property (@(posedge clk) disable iff (!rstN)
      (statW[g][12] && !(rdEn && addr == POP_ADDR)) |=> statW[g][12]);
  end
endmodule

bind adc_seq_sampler adc_seq_sampler_chk u_chk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .rdEn(rdEn), .addr(addr),
  .irqOut(irqOut), .actSel(actSel), .evMux(evMux), .intMask(intMask),
  .rawSt(rawSt), .statW(statW)
);

// File: tb/adc_seq_sampler_bench.sv
module adc_seq_sampler_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, trigIn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irqOut;

  int testsRun = 0, testsFailed = 0;

  always #2 clk = ~clk;  // 250 MHz

  adc_seq_sampler u_adc_seq_sampler (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trigIn(trigIn), .irqOut(irqOut)
  );

  // register table: {address, write value, expected readback}
  localparam logic [71:0] REG_VEC [8] = '{
    {8'h40, 32'hFFFF_FFFF, 32'h3333_3333},
    {8'h60, 32'h1234_5678, 32'h1230_1230},
    {8'h00, 32'hFFFF_FFFF, 32'h0000_000F},
    {8'h00, 32'h0000_0005, 32'h0000_0005},
    {8'h08, 32'hFFFF_FFFF, 32'h0000_000F},
    {8'h08, 32'h0000_0000, 32'h0000_0000},
    {8'h14, 32'hFFFF_ABCD, 32'h0000_ABCD},
    {8'hA4, 32'hDEAD_BEEF, 32'hDEAD_BEEF}
  };

  // reference model
  logic [31:0] mNoise = '0;
  logic [9:0]  mData [4][16];
  int          mRd [4] = '{0, 0, 0, 0};
  int          mWr [4] = '{0, 0, 0, 0};
  int          mCnt [4] = '{0, 0, 0, 0};
  logic [3:0]  mAct = '0;
  logic [15:0] mEv = '0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic trig();
    @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
    for (int n = 0; n < 4; n++) begin
      if (mAct[n] && mEv[4*n +: 4] == 4'd5) begin
        mNoise = mNoise * 32'd314159 + 32'd1;
        if (mCnt[n] < 16) begin
          mData[n][mWr[n]] = 10'h200 + 10'(mNoise[18:16]);
          mWr[n] = (mWr[n] + 1) % 16;
          mCnt[n]++;
        end
      end
    end
  endtask

  function automatic logic [31:0] expStat(input int n);
    return {19'd0, (mCnt[n] == 16), 3'b000, (mCnt[n] == 0), 4'(mWr[n]), 4'(mRd[n])};
  endfunction

  task automatic popChk(input int n, input string req);
    logic [31:0] d;
    rdReg(8'h48 + 8'(32 * n), d);
    if (mCnt[n] > 0) begin
      chk(req, d, 32'(mData[n][mRd[n]]));
      mRd[n] = (mRd[n] + 1) % 16;
      mCnt[n]--;
    end
  endtask

  task automatic statChk(input int n, input string req);
    logic [31:0] d;
    rdReg(8'h4C + 8'(32 * n), d);
    chk(req, d, expStat(n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int n = 0; n < 4; n++) begin
      rdReg(8'h4C + 8'(32 * n), d);
      chk("R1 status", d, 32'h100);
    end
    rdReg(8'h04, d); chk("R1 raw", d, 32'h0);
    rdReg(8'h10, d); chk("R1 ovf", d, 32'h0);
    chk("R1 irq", 32'(irqOut), 32'h0);

    // R10: register field masking, table driven
    foreach (REG_VEC[i]) begin
      wrReg(REG_VEC[i][71:64], REG_VEC[i][63:32]);
      rdReg(REG_VEC[i][71:64], d);
      chk("R10 readback", d, REG_VEC[i][31:0]);
    end

    // R2: seq0,1 selected; seq2 enabled but wrong code; seq3 code but disabled
    mAct = 4'b0111; mEv = 16'h5055;
    wrReg(8'h08, 32'h0);
    wrReg(8'h00, 32'(mAct));
    wrReg(8'h14, 32'(mEv));
    trig();
    for (int n = 0; n < 4; n++) statChk(n, "R2 fan-out status");
    rdReg(8'h04, d); chk("R7 raw set", d, 32'h3);
    chk("R8 irq masked off", 32'(irqOut), 32'h0);
    wrReg(8'h08, 32'h1);
    chk("R8 irq line", 32'(irqOut), 32'h1);
    rdReg(8'h0C, d); chk("R8 masked read", d, 32'h1);
    wrReg(8'h0C, 32'h1);
    rdReg(8'h04, d); chk("R7 w1c raw", d, 32'h2);

    // R3/R4: values and pop behaviour
    popChk(0, "R3 sample seq0");
    statChk(0, "R4 status after pop");
    popChk(1, "R3 sample seq1");
    statChk(1, "R4 status seq1");
    rdReg(8'h68, d);
    statChk(1, "R5 empty read holds");

    // R6: fill seq0 from rd=1, then overflow
    mAct = 4'b0001;
    wrReg(8'h00, 32'(mAct));
    for (int k = 0; k < 16; k++) trig();
    statChk(0, "R4 full flag");
    trig();
    statChk(0, "R6 drop keeps status");
    rdReg(8'h10, d); chk("R6 overflow bit", d, 32'h1);
    wrReg(8'h10, 32'h1);
    rdReg(8'h10, d); chk("R9 overflow w1c", d, 32'h0);

    // R4: drain through pointer wrap
    popChk(0, "R4 first pop from full");
    statChk(0, "R4 full cleared");
    for (int k = 0; k < 15; k++) popChk(0, "R4 drain order");
    statChk(0, "R4 empty after drain");

    // R3: noise advanced across the dropped sample
    trig();
    popChk(0, "R3 noise after drop");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule